// File: doc/BRIEF.md
# Sampled-Signal Peak Detector

This block watches a stream of unsigned samples, each marked by a one-cycle valid strobe, and finds the local maxima of the waveform. Every valid sample is compared with the sample before it, giving a three-way class: greater, equal or less. The class must repeat on a set number of consecutive samples before it is believed. This stops a single stray sample from flipping the direction the block thinks the signal is moving in. Accepted rises set a rising-state flag. Accepted falls clear it, but only if the falling sample is still above a programmable amplitude gate. The fall of that flag is the peak.

Each peak is reported two ways. The first is a one-cycle event for logic in the same clock domain. The second is a stretched pulse of programmable length for slower consumers. Equal samples (plateaus) never set or clear the rising state. So a flat top is reported once, on the first confirmed fall after it. A low bump that never clears the gate produces nothing. The first sample after reset only primes the history register.

Top module: `peak_detect`

## Requirements
- R1: While reset is held and right after it, `peak_evt` and `peak_pulse` are low and the rising state is clear. The first valid sample after reset is only stored: it yields no comparison, so it can take no part in a peak.
- R2: Each later valid sample is classed as greater, equal or less than the previous valid sample. Cycles with `smp_valid` low are ignored whatever `smp_data` holds.
- R3: A class acts on the rising state only on a comparison that is the DEBOUNCE_N-th (or later) consecutive comparison of that same class. With DEBOUNCE_N = 2, a single opposite sample inside a ramp has no effect.
- R4: An accepted greater class sets the rising state. An accepted equal class leaves it unchanged, so a plateau neither declares nor cancels a peak.
- R5: An accepted less class clears the rising state only when the current sample is strictly greater than `amp_thresh`. A fall at or below the gate leaves the state set.
- R6: A 1-to-0 change of the rising state raises `peak_evt` for exactly one cycle. That cycle begins at the second clock edge after the edge that samples the clearing sample.
- R7: `peak_pulse` goes high in the same cycle as `peak_evt`. It stays high for `pulse_len` cycles in total, or one cycle when `pulse_len` is 0, counted from the most recent event. A new event during a pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | SAMPLE_W | Unsigned sample value |
| amp_thresh | input | SAMPLE_W | Amplitude gate for the clearing sample |
| pulse_len | input | LEN_W | Stretched pulse length in cycles |
| peak_evt | output | 1 | One-cycle peak event |
| peak_pulse | output | 1 | Stretched peak pulse |

## Verification
Two functions can overlap in one cycle: a new peak event, and the stretcher that is still counting down from the previous event. Back-to-back samples form two peaks five cycles apart while the length is 12. The bench checks that the pulse stays high for a single unbroken 17-cycle span, and that both events appear. A second overlap is a new valid sample entering the compare stage while earlier results are still moving through the filter and rising stages. Random walks with zero to two idle cycles between samples cover this, and every cycle is checked against an arithmetic model of the sample sequence.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_GT = 2'd1,
        CMP_LT = 2'd2
    } cmp_e;
endpackage

// File: rtl/pkd_compare.sv
module pkd_compare
    import pkd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         res_vld,
    output cmp_e         res_cls,
    output logic [W-1:0] res_data
);
    typedef struct packed {
        logic         first;
        logic [W-1:0] prev;
        logic         vld;
        cmp_e         cls;
        logic [W-1:0] data;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (in_vld) begin
            if (s_q.first) begin
                s_d.first = 1'b0;
            end else begin
                s_d.vld  = 1'b1;
                s_d.data = in_data;
                if (in_data > s_q.prev)       s_d.cls = CMP_GT;
                else if (in_data == s_q.prev) s_d.cls = CMP_EQ;
                else                          s_d.cls = CMP_LT;
            end
            // history is overwritten after the comparison above was formed
            s_d.prev = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.first <= 1'b1;
            s_q.prev  <= '0;
            s_q.vld   <= 1'b0;
            s_q.cls   <= CMP_EQ;
            s_q.data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign res_vld  = s_q.vld;
    assign res_cls  = s_q.cls;
    assign res_data = s_q.data;

    p_first_primes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && s_q.first) |=> !res_vld);
    p_result_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(in_vld));
    p_gt_is_larger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_cls == CMP_GT) |-> (res_data > $past(s_q.prev)));
    p_lt_is_smaller_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_cls == CMP_LT) |-> (res_data < $past(s_q.prev)));
endmodule

// File: rtl/pkd_debounce.sv
module pkd_debounce
    import pkd_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  cmp_e         in_cls,
    input  logic [W-1:0] in_data,
    output logic         acc_vld,
    output cmp_e         acc_cls,
    output logic [W-1:0] acc_data
);
    typedef struct packed {
        logic         vld;
        cmp_e         cls;
        logic [W-1:0] data;
    } acc_t;

    acc_t acc_d, acc_q;

    generate
        if (N <= 1) begin : g_direct
            always_comb begin
                acc_d     = acc_q;
                acc_d.vld = in_vld;
                if (in_vld) begin
                    acc_d.cls  = in_cls;
                    acc_d.data = in_data;
                end
            end
        end else begin : g_count
            localparam int CW = $clog2(N + 1);
            localparam logic [CW-1:0] RUN_MAX = CW'(N);

            typedef struct packed {
                cmp_e          last;
                logic [CW-1:0] run;
            } run_t;

            run_t          run_d, run_q;
            logic [CW-1:0] run_nx;

            always_comb begin
                run_d = run_q;
                acc_d = acc_q;
                acc_d.vld = 1'b0;
                run_nx = run_q.run;
                if (in_vld) begin
                    if (in_cls == run_q.last)
                        run_nx = (run_q.run == RUN_MAX) ? RUN_MAX : run_q.run + 1'b1;
                    else
                        run_nx = CW'(1);
                    run_d.last = in_cls;
                    run_d.run  = run_nx;
                    if (run_nx >= RUN_MAX) begin
                        acc_d.vld  = 1'b1;
                        acc_d.cls  = in_cls;
                        acc_d.data = in_data;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    run_q.last <= CMP_EQ;
                    run_q.run  <= '0;
                end else begin
                    run_q <= run_d;
                end
            end

            p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
                run_q.run <= RUN_MAX);
            p_accept_repeats_r3: assert property (@(posedge clk) disable iff (!rst_n)
                acc_vld |-> ($past(run_q.last) == acc_cls));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.vld  <= 1'b0;
            acc_q.cls  <= CMP_EQ;
            acc_q.data <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_vld  = acc_q.vld;
    assign acc_cls  = acc_q.cls;
    assign acc_data = acc_q.data;

    p_accept_needs_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> $past(in_vld));
endmodule

// File: rtl/pkd_rise_track.sv
module pkd_rise_track
    import pkd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_vld,
    input  cmp_e         acc_cls,
    input  logic [W-1:0] acc_data,
    input  logic [W-1:0] thresh,
    output logic         peak_evt
);
    typedef struct packed {
        logic rise;
        logic evt;
    } st_t;

    st_t  s_d, s_q;
    logic set_c, clr_c;

    always_comb begin
        set_c = acc_vld && (acc_cls == CMP_GT);
        clr_c = acc_vld && (acc_cls == CMP_LT) && (acc_data > thresh);
        s_d   = s_q;
        if (set_c)      s_d.rise = 1'b1;
        else if (clr_c) s_d.rise = 1'b0;
        s_d.evt = s_q.rise && !s_d.rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.rise <= 1'b0;
            s_q.evt  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign peak_evt = s_q.evt;

    p_rise_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_cls == CMP_GT) |=> s_q.rise);
    p_plateau_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_cls == CMP_EQ) |=> $stable(s_q.rise));
    p_low_fall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_cls == CMP_LT && acc_data <= thresh) |=> $stable(s_q.rise));
    p_evt_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        peak_evt |-> ($past(s_q.rise) && !s_q.rise));
endmodule

// File: rtl/pkd_stretch.sv
module pkd_stretch #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [LW-1:0] len,
    output logic          pulse
);
    typedef struct packed {
        logic [LW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (evt)
            s_d.cnt = (len == '0) ? '0 : len - 1'b1;
        else if (s_q.cnt != '0)
            s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.cnt <= '0;
        else        s_q <= s_d;
    end

    assign pulse = evt || (s_q.cnt != '0);

    p_pulse_covers_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> pulse);
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (s_q.cnt == (($past(len) == '0) ? '0 : $past(len) - 1'b1)));
    p_tail_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && s_q.cnt != '0) |=> (s_q.cnt < $past(s_q.cnt)));
endmodule

// File: rtl/peak_detect.sv
module peak_detect
    import pkd_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int DEBOUNCE_N = 2,
    parameter int LEN_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] amp_thresh,
    input  logic [LEN_W-1:0]    pulse_len,
    output logic                peak_evt,
    output logic                peak_pulse
);
    logic                res_vld;
    cmp_e                res_cls;
    logic [SAMPLE_W-1:0] res_data;
    logic                acc_vld;
    cmp_e                acc_cls;
    logic [SAMPLE_W-1:0] acc_data;

    pkd_compare #(.W(SAMPLE_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .in_vld(smp_valid), .in_data(smp_data),
        .res_vld(res_vld), .res_cls(res_cls), .res_data(res_data)
    );

    pkd_debounce #(.W(SAMPLE_W), .N(DEBOUNCE_N)) u_deb (
        .clk(clk), .rst_n(rst_n),
        .in_vld(res_vld), .in_cls(res_cls), .in_data(res_data),
        .acc_vld(acc_vld), .acc_cls(acc_cls), .acc_data(acc_data)
    );

    pkd_rise_track #(.W(SAMPLE_W)) u_rise (
        .clk(clk), .rst_n(rst_n),
        .acc_vld(acc_vld), .acc_cls(acc_cls), .acc_data(acc_data),
        .thresh(amp_thresh), .peak_evt(peak_evt)
    );

    pkd_stretch #(.LW(LEN_W)) u_str (
        .clk(clk), .rst_n(rst_n),
        .evt(peak_evt), .len(pulse_len), .pulse(peak_pulse)
    );

    p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        peak_evt |=> !peak_evt);
    p_evt_traces_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        peak_evt |-> $past(acc_vld));
endmodule

// File: tb/peak_detect_test.sv
module peak_detect_test;
    logic       clk, rst_n, smp_valid;
    logic [7:0] smp_data, amp_thresh;
    logic [3:0] pulse_len;
    logic       peak_evt, peak_pulse;

    peak_detect uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .amp_thresh(amp_thresh), .pulse_len(pulse_len),
        .peak_evt(peak_evt), .peak_pulse(peak_pulse)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int evt_seen = 0, hi_seen = 0, last_evt = -1000;
    bit ring [8];
    bit done = 0;

    // sample-level model: 0 equal, 1 greater, 2 less
    bit m_first = 1; int m_prev = 0, m_last = 0, m_run = 0; bit m_rise = 0;
    localparam int DN = 2;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_first = 1; m_prev = 0; m_last = 0; m_run = 0; m_rise = 0;
        for (int i = 0; i < 8; i++) ring[i] = 0;
    endtask

    task automatic model_step(int v);
        int r; bit old;
        if (m_first) begin m_first = 0; m_prev = v; return; end
        r = (v > m_prev) ? 1 : (v == m_prev) ? 0 : 2;
        m_prev = v;
        m_run = (r == m_last) ? ((m_run >= DN) ? DN : m_run + 1) : 1;
        m_last = r;
        old = m_rise;
        if (m_run >= DN) begin
            if (r == 1) m_rise = 1;
            else if (r == 2 && v > int'(amp_thresh)) m_rise = 0;
        end
        if (old && !m_rise) ring[(cyc + 3) % 8] = 1;
    endtask

    // per-cycle monitor (R6 event timing, R7 pulse shape)
    always @(negedge clk) begin
        bit e, p; int len;
        e = ring[cyc % 8]; ring[cyc % 8] = 0;
        if (!rst_n) begin
            last_evt = -1000;
        end else begin
            if (e) last_evt = cyc;
            len = (pulse_len == 0) ? 1 : int'(pulse_len);
            p = (cyc - last_evt) < len;
            chk(peak_evt == e, "R6 peak_evt", peak_evt, e);
            chk(peak_pulse == p, "R7 peak_pulse", peak_pulse, p);
            if (peak_evt) evt_seen++;
            if (peak_pulse) hi_seen++;
        end
    end

    task automatic send(int v, int gap);
        smp_valid = 1; smp_data = 8'(v);
        model_step(v);
        @(negedge clk);
        if (gap > 0) begin
            smp_valid = 0; smp_data = 8'hFF;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        smp_valid = 0; smp_data = 8'hFF;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_cnt(string tag, int base, int exp);
        idle(6);
        chk(evt_seen - base == exp, tag, evt_seen - base, exp);
    endtask

    task automatic do_reset();
        idle(1);
        rst_n = 0; model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(peak_evt == 0 && peak_pulse == 0, "R1 outputs after reset",
            {peak_evt, peak_pulse}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, hb, v;
        logic [15:0] lfsr;
        rst_n = 0; smp_valid = 0; smp_data = 0; amp_thresh = 0; pulse_len = 3;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(peak_evt == 0 && peak_pulse == 0, "R1 reset state", {peak_evt, peak_pulse}, 0);

        // R1: first sample only primes history
        base = evt_seen;
        send(200, 1); send(100, 1); send(90, 1); send(80, 1);
        expect_cnt("R1 first sample no peak", base, 0);

        // R2: idle cycles carry junk data and must be ignored
        base = evt_seen;
        send(10, 3); send(20, 3); send(30, 3); send(20, 3); send(10, 3);
        expect_cnt("R2 strobed compare peak", base, 1);

        // R3: single dip inside a ramp is filtered
        base = evt_seen;
        send(40, 0); send(50, 0); send(60, 0); send(55, 0);
        send(70, 0); send(80, 0); send(90, 0); send(100, 0);
        expect_cnt("R3 spike ignored", base, 0);
        send(90, 0); send(80, 0);
        expect_cnt("R3 confirmed fall", base, 1);

        // R4: plateau
        base = evt_seen;
        send(90, 0); send(100, 0);
        for (int i = 0; i < 4; i++) send(100, 0);
        expect_cnt("R4 plateau no peak", base, 0);
        send(90, 0); send(80, 0);
        expect_cnt("R4 peak after plateau", base, 1);

        // R5: amplitude gate
        amp_thresh = 120;
        base = evt_seen;
        send(90, 0); send(100, 0); send(110, 0); send(100, 0);
        send(90, 0); send(80, 0); send(70, 0);
        expect_cnt("R5 below gate", base, 0);
        send(130, 0); send(160, 0); send(200, 0); send(180, 0); send(150, 0);
        expect_cnt("R5 above gate", base, 1);
        amp_thresh = 150;
        base = evt_seen;
        send(170, 0); send(190, 0); send(160, 0); send(150, 0);
        expect_cnt("R5 equal to gate", base, 0);
        send(200, 0); send(220, 0); send(170, 0); send(151, 0);
        expect_cnt("R5 just above gate", base, 1);

        // R7: pulse length sweep
        amp_thresh = 0;
        for (int l = 0; l < 16; l++) begin
            pulse_len = 4'(l);
            base = evt_seen; hb = hi_seen;
            send(20, 0); send(40, 0); send(60, 0); send(80, 0);
            send(60, 0); send(40, 0); send(20, 0);
            idle(25);
            chk(evt_seen - base == 1, "R6 single event", evt_seen - base, 1);
            chk(hi_seen - hb == ((l == 0) ? 1 : l), "R7 pulse width",
                hi_seen - hb, (l == 0) ? 1 : l);
        end

        // R7: retrigger while pulse runs
        pulse_len = 12;
        base = evt_seen; hb = hi_seen;
        send(20, 0); send(40, 0); send(60, 0); send(80, 0); send(60, 0); send(40, 0);
        send(60, 0); send(80, 0); send(100, 0); send(80, 0); send(60, 0);
        idle(25);
        chk(evt_seen - base == 2, "R7 retrigger events", evt_seen - base, 2);
        chk(hi_seen - hb == 17, "R7 retrigger width", hi_seen - hb, 17);

        // random walks across gates and lengths
        lfsr = 16'hACE1; v = 128;
        for (int t = 0; t < 4; t++) begin
            amp_thresh = 8'(t * 64);
            pulse_len = 4'(1 + t * 3);
            idle(4);
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v = v + int'(lfsr[3:0] % 9) - 4;
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                send(v, int'(lfsr[9:8] % 3));
            end
            idle(20);
        end

        // R1: reset mid-stream then first sample only primes
        pulse_len = 3; amp_thresh = 0;
        send(10, 0); send(50, 0); send(90, 0);
        do_reset();
        base = evt_seen;
        send(200, 0); send(100, 0); send(50, 0); send(20, 0);
        expect_cnt("R1 no peak after reset", base, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule